// File: doc/BRIEF.md
# AXI-Lite Protocol Firewall

This block sits between a trusted AXI-Lite master and a downstream slave region that is not trusted. While it is healthy, it forwards all five channels without change and adds no cycles. It watches every handshake as it passes. It looks for three kinds of trouble: a stall that lasts too long, a response that no request asked for, and a VALID that is withdrawn before its READY arrives.

On the first such event the block trips. It cuts the slave off by holding every downstream VALID and READY low. From then on it answers the master itself. This covers responses that were already owed and every new request. Each answer carries an error code, so the master and its interconnect always see a complete transaction. A management agent receives a one-cycle interrupt and a frozen cause word. The tripped state clears only on reset.

Each channel has its own stall limit, given as a packed input. The block keeps count of outstanding requests, so a run of posted transactions can be tracked and completed after a trip.

Top module: `axil_guard`

## Requirements
- R1: After reset, `tripped`, `trip_irq` and `trip_status` are all zero.
- R2: While not tripped, the request channels and the response channels are forwarded unchanged between the two sides. This includes address, write data, strobes, read data and the BRESP/RRESP codes.
- R3: The block trips at the end of the (L+1)-th consecutive cycle in which the channel waits, where L is that channel's limit. For AW, W or AR, the channel waits when the master holds VALID and the slave withholds READY.
- R4: For B or R, the same rule applies. The channel waits when at least one response is owed and the slave holds VALID low.
- R5: The block trips in the same cycle as a downstream BVALID that arrives when no write is owed, or an RVALID that arrives when no read is owed.
- R6: If VALID was high without READY at a clock edge and is low in the next cycle, the block trips at the end of that cycle. This applies to any channel.
- R7: `trip_status` is captured in the trip cycle. Bits 4:0 mark the channels involved, one bit each: 0=AW, 1=W, 2=B, 3=AR, 4=R. Bit 5 means a stall expired. Bit 6 means a violation.
- R8: `trip_irq` is high for exactly one cycle, namely the first cycle in which `tripped` is high.
- R9: While tripped, m_awvalid, m_wvalid, m_arvalid, m_bready and m_rready are low. Any downstream READY, VALID or data is ignored.
- R10: While tripped, AW, W and AR are accepted by the block. B is presented with response code 2 (SLVERR) in the cycle after a write has both its address and its data. R is presented with SLVERR and RDATA=0 in the cycle after the read address. Responses that were owed at the trip are completed the same way.
- R11: Once tripped, `tripped` stays high and `trip_status` stays constant until reset.
- R12: Events on several channels in the same cycle are all recorded in `trip_status`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| stall_limit | input | 5*TO_W | Stall limit per channel, slice c = channel c |
| s_awvalid | input | 1 | Master write address valid |
| s_awready | output | 1 | Write address ready to master |
| s_awaddr | input | ADDR_W | Master write address |
| s_wvalid | input | 1 | Master write data valid |
| s_wready | output | 1 | Write data ready to master |
| s_wdata | input | DATA_W | Master write data |
| s_wstrb | input | DATA_W/8 | Master write strobes |
| s_bvalid | output | 1 | Write response valid to master |
| s_bready | input | 1 | Master write response ready |
| s_bresp | output | 2 | Write response code to master |
| s_arvalid | input | 1 | Master read address valid |
| s_arready | output | 1 | Read address ready to master |
| s_araddr | input | ADDR_W | Master read address |
| s_rvalid | output | 1 | Read data valid to master |
| s_rready | input | 1 | Master read data ready |
| s_rdata | output | DATA_W | Read data to master |
| s_rresp | output | 2 | Read response code to master |
| m_awvalid | output | 1 | Write address valid to slave |
| m_awready | input | 1 | Slave write address ready |
| m_awaddr | output | ADDR_W | Write address to slave |
| m_wvalid | output | 1 | Write data valid to slave |
| m_wready | input | 1 | Slave write data ready |
| m_wdata | output | DATA_W | Write data to slave |
| m_wstrb | output | DATA_W/8 | Write strobes to slave |
| m_bvalid | input | 1 | Slave write response valid |
| m_bready | output | 1 | Write response ready to slave |
| m_bresp | input | 2 | Slave write response code |
| m_arvalid | output | 1 | Read address valid to slave |
| m_arready | input | 1 | Slave read address ready |
| m_araddr | output | ADDR_W | Read address to slave |
| m_rvalid | input | 1 | Slave read data valid |
| m_rready | output | 1 | Read data ready to slave |
| m_rdata | input | DATA_W | Slave read data |
| m_rresp | input | 2 | Slave read response code |
| tripped | output | 1 | Sticky isolation state |
| trip_irq | output | 1 | One-cycle trip interrupt |
| trip_status | output | 7 | Frozen trip cause word |

## Verification
Two detectors on different channels can fire in the same cycle. The bench provokes this by raising the write address and the read address together toward a slave that never asserts READY, with both channels given the same stall limit. Both channels then expire on the same edge. The check requires the trip to occur after exactly L+1 waiting cycles and the cause word to hold the stall bit plus both the AW and the AR channel bits. A second coincidence is a response that was owed at the moment of the trip. It must be completed as SLVERR in the very next cycle, with no gap on the master side.

// File: rtl/axil_guard_pkg.sv
package axil_guard_pkg;
  localparam int NCH   = 5;
  localparam int CH_AW = 0;
  localparam int CH_W  = 1;
  localparam int CH_B  = 2;
  localparam int CH_AR = 3;
  localparam int CH_R  = 4;
  localparam int STAT_W = NCH + 2;
  localparam logic [1:0] RESP_SLVERR = 2'b10;

  // cause word: [6] violation, [5] stall expired, [4:0] channel mask
  typedef struct packed {
    logic           viol;
    logic           stall;
    logic [NCH-1:0] chan;
  } cause_t;
endpackage

// File: rtl/axil_guard_watch.sv
module axil_guard_watch #(
  parameter int TO_W = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            en,
  input  logic [TO_W-1:0] limit,
  input  logic            hs_valid,
  input  logic            hs_ready,
  input  logic            waiting,
  output logic            expired,
  output logic            dropped
);
  logic [TO_W-1:0] cnt_q, cnt_d;
  logic            pend_q, pend_d;
  logic            cnt_full;

  assign cnt_full = (cnt_q == {TO_W{1'b1}});

  always_comb begin
    expired = en & waiting & (cnt_q >= limit);
    dropped = en & pend_q & ~hs_valid;
    pend_d  = en & hs_valid & ~hs_ready;
    if (en && waiting) begin
      cnt_d = cnt_full ? cnt_q : cnt_q + 1'b1;
    end else begin
      cnt_d = '0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      pend_q <= 1'b0;
    end else begin
      cnt_q  <= cnt_d;
      pend_q <= pend_d;
    end
  end
endmodule

// File: rtl/axil_guard_track.sv
module axil_guard_track #(
  parameter int OUT_W = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic aw_hs,
  input  logic w_hs,
  input  logic b_hs,
  input  logic ar_hs,
  input  logic r_hs,
  output logic exp_b,
  output logic exp_r,
  output logic aw_room,
  output logic w_room,
  output logic ar_room
);
  logic [OUT_W-1:0] aw_q, aw_d, w_q, w_d, ar_q, ar_d;
  logic b_take, r_take;

  always_comb begin
    exp_b   = (aw_q != '0) && (w_q != '0);
    exp_r   = (ar_q != '0);
    aw_room = (aw_q != {OUT_W{1'b1}});
    w_room  = (w_q  != {OUT_W{1'b1}});
    ar_room = (ar_q != {OUT_W{1'b1}});
    b_take  = b_hs & exp_b;
    r_take  = r_hs & exp_r;
    aw_d = aw_q + OUT_W'(aw_hs) - OUT_W'(b_take);
    w_d  = w_q  + OUT_W'(w_hs)  - OUT_W'(b_take);
    ar_d = ar_q + OUT_W'(ar_hs) - OUT_W'(r_take);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      aw_q <= '0;
      w_q  <= '0;
      ar_q <= '0;
    end else begin
      aw_q <= aw_d;
      w_q  <= w_d;
      ar_q <= ar_d;
    end
  end
endmodule

// File: rtl/axil_guard_trip.sv
module axil_guard_trip
  import axil_guard_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NCH-1:0]    stall_hit,
  input  logic [NCH-1:0]    viol_hit,
  output logic              tripped,
  output logic              trip_irq,
  output logic [STAT_W-1:0] trip_status
);
  logic   trip_q, trip_d, irq_q, irq_d, fire;
  cause_t stat_q, stat_d;

  always_comb begin
    fire   = ~trip_q & ((|stall_hit) | (|viol_hit));
    trip_d = trip_q | fire;
    irq_d  = fire;
    stat_d = stat_q;
    if (fire) begin
      stat_d.viol  = |viol_hit;
      stat_d.stall = |stall_hit;
      stat_d.chan  = stall_hit | viol_hit;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      trip_q <= 1'b0;
      irq_q  <= 1'b0;
      stat_q <= '0;
    end else begin
      trip_q <= trip_d;
      irq_q  <= irq_d;
      stat_q <= stat_d;
    end
  end

  assign tripped     = trip_q;
  assign trip_irq    = irq_q;
  assign trip_status = stat_q;
endmodule

// File: rtl/axil_guard.sv
module axil_guard
  import axil_guard_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 32,
  parameter int TO_W   = 8,
  parameter int OUT_W  = 4
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [NCH*TO_W-1:0]   stall_limit,
  input  logic                  s_awvalid,
  output logic                  s_awready,
  input  logic [ADDR_W-1:0]     s_awaddr,
  input  logic                  s_wvalid,
  output logic                  s_wready,
  input  logic [DATA_W-1:0]     s_wdata,
  input  logic [DATA_W/8-1:0]   s_wstrb,
  output logic                  s_bvalid,
  input  logic                  s_bready,
  output logic [1:0]            s_bresp,
  input  logic                  s_arvalid,
  output logic                  s_arready,
  input  logic [ADDR_W-1:0]     s_araddr,
  output logic                  s_rvalid,
  input  logic                  s_rready,
  output logic [DATA_W-1:0]     s_rdata,
  output logic [1:0]            s_rresp,
  output logic                  m_awvalid,
  input  logic                  m_awready,
  output logic [ADDR_W-1:0]     m_awaddr,
  output logic                  m_wvalid,
  input  logic                  m_wready,
  output logic [DATA_W-1:0]     m_wdata,
  output logic [DATA_W/8-1:0]   m_wstrb,
  input  logic                  m_bvalid,
  output logic                  m_bready,
  input  logic [1:0]            m_bresp,
  output logic                  m_arvalid,
  input  logic                  m_arready,
  output logic [ADDR_W-1:0]     m_araddr,
  input  logic                  m_rvalid,
  output logic                  m_rready,
  input  logic [DATA_W-1:0]     m_rdata,
  input  logic [1:0]            m_rresp,
  output logic                  tripped,
  output logic                  trip_irq,
  output logic [STAT_W-1:0]     trip_status
);
  logic [1:0] rst_sync_q;
  logic       rst_i_n;
  logic       exp_b, exp_r, aw_room, w_room, ar_room;
  logic       live;
  logic [NCH-1:0] hv, hr, hw, expired, dropped, unexp;
  logic [NCH-1:0] stall_hit, viol_hit;

  // asynchronous assertion, release aligned to the clock
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_sync_q <= 2'b00;
    end else begin
      rst_sync_q <= {rst_sync_q[0], 1'b1};
    end
  end
  assign rst_i_n = rst_sync_q[1];
  assign live    = ~tripped;

  // master-facing mux: slave path while healthy, local answers once tripped
  always_comb begin
    m_awvalid = s_awvalid & live;
    m_wvalid  = s_wvalid  & live;
    m_arvalid = s_arvalid & live;
    m_bready  = s_bready  & live;
    m_rready  = s_rready  & live;
    m_awaddr  = s_awaddr;
    m_wdata   = s_wdata;
    m_wstrb   = s_wstrb;
    m_araddr  = s_araddr;
    s_awready = live ? m_awready : aw_room;
    s_wready  = live ? m_wready  : w_room;
    s_arready = live ? m_arready : ar_room;
    s_bvalid  = live ? m_bvalid  : exp_b;
    s_bresp   = live ? m_bresp   : RESP_SLVERR;
    s_rvalid  = live ? m_rvalid  : exp_r;
    s_rresp   = live ? m_rresp   : RESP_SLVERR;
    s_rdata   = live ? m_rdata   : '0;
  end

  axil_guard_track #(.OUT_W(OUT_W)) u_track (
    .clk    (clk),
    .rst_n  (rst_i_n),
    .aw_hs  (s_awvalid & s_awready),
    .w_hs   (s_wvalid  & s_wready),
    .b_hs   (s_bvalid  & s_bready),
    .ar_hs  (s_arvalid & s_arready),
    .r_hs   (s_rvalid  & s_rready),
    .exp_b  (exp_b),
    .exp_r  (exp_r),
    .aw_room(aw_room),
    .w_room (w_room),
    .ar_room(ar_room)
  );

  // per-channel view: the VALID owner, the READY owner, the wait condition
  always_comb begin
    hv[CH_AW] = s_awvalid; hr[CH_AW] = m_awready; hw[CH_AW] = s_awvalid & ~m_awready;
    hv[CH_W]  = s_wvalid;  hr[CH_W]  = m_wready;  hw[CH_W]  = s_wvalid  & ~m_wready;
    hv[CH_AR] = s_arvalid; hr[CH_AR] = m_arready; hw[CH_AR] = s_arvalid & ~m_arready;
    hv[CH_B]  = m_bvalid;  hr[CH_B]  = s_bready;  hw[CH_B]  = exp_b & ~m_bvalid;
    hv[CH_R]  = m_rvalid;  hr[CH_R]  = s_rready;  hw[CH_R]  = exp_r & ~m_rvalid;
    unexp        = '0;
    unexp[CH_B]  = live & m_bvalid & ~exp_b;
    unexp[CH_R]  = live & m_rvalid & ~exp_r;
  end

  for (genvar c = 0; c < NCH; c++) begin : g_watch
    axil_guard_watch #(.TO_W(TO_W)) u_watch (
      .clk     (clk),
      .rst_n   (rst_i_n),
      .en      (live),
      .limit   (stall_limit[c*TO_W +: TO_W]),
      .hs_valid(hv[c]),
      .hs_ready(hr[c]),
      .waiting (hw[c]),
      .expired (expired[c]),
      .dropped (dropped[c])
    );
  end

  assign stall_hit = expired;
  assign viol_hit  = dropped | unexp;

  axil_guard_trip u_trip (
    .clk        (clk),
    .rst_n      (rst_i_n),
    .stall_hit  (stall_hit),
    .viol_hit   (viol_hit),
    .tripped    (tripped),
    .trip_irq   (trip_irq),
    .trip_status(trip_status)
  );
endmodule

// File: rtl/axil_guard_chk.sv
module axil_guard_chk
  import axil_guard_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic              tripped,
  input logic              trip_irq,
  input logic [STAT_W-1:0] trip_status,
  input logic              m_awvalid,
  input logic              m_wvalid,
  input logic              m_arvalid,
  input logic              m_bready,
  input logic              m_rready,
  input logic              s_bvalid,
  input logic [1:0]        s_bresp,
  input logic              s_rvalid,
  input logic [1:0]        s_rresp
);
  // R11
  trip_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tripped |=> tripped);

  // R11
  status_frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tripped |=> $stable(trip_status));

  // R9
  isolate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tripped |-> !m_awvalid && !m_wvalid && !m_arvalid && !m_bready && !m_rready);

  // R8
  irq_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    trip_irq |=> !trip_irq && tripped);

  // R7
  cause_nonzero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tripped |-> (trip_status[NCH-1:0] != '0) && (trip_status[STAT_W-1:NCH] != '0));

  // R1
  idle_clean_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !tripped |-> (trip_status == '0) && !trip_irq);

  // R10
  err_b_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tripped && s_bvalid |-> s_bresp == RESP_SLVERR);

  // R10
  err_r_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tripped && s_rvalid |-> s_rresp == RESP_SLVERR);
endmodule

bind axil_guard axil_guard_chk u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .tripped    (tripped),
  .trip_irq   (trip_irq),
  .trip_status(trip_status),
  .m_awvalid  (m_awvalid),
  .m_wvalid   (m_wvalid),
  .m_arvalid  (m_arvalid),
  .m_bready   (m_bready),
  .m_rready   (m_rready),
  .s_bvalid   (s_bvalid),
  .s_bresp    (s_bresp),
  .s_rvalid   (s_rvalid),
  .s_rresp    (s_rresp)
);

// File: tb/axil_guard_test.sv
`timescale 1ns/1ps
module axil_guard_test;
  localparam int AW = 8, DW = 32, TW = 4;

  logic clk, rst_n;
  logic [5*TW-1:0] stall_limit;
  logic s_awvalid, s_awready, s_wvalid, s_wready, s_bvalid, s_bready;
  logic s_arvalid, s_arready, s_rvalid, s_rready;
  logic [AW-1:0] s_awaddr, s_araddr, m_awaddr, m_araddr;
  logic [DW-1:0] s_wdata, m_wdata, s_rdata, m_rdata;
  logic [DW/8-1:0] s_wstrb, m_wstrb;
  logic [1:0] s_bresp, s_rresp, m_bresp, m_rresp;
  logic m_awvalid, m_awready, m_wvalid, m_wready, m_bvalid, m_bready;
  logic m_arvalid, m_arready, m_rvalid, m_rready;
  logic tripped, trip_irq;
  logic [6:0] trip_status;

  int n_chk = 0, n_fail = 0;

  axil_guard #(.ADDR_W(AW), .DATA_W(DW), .TO_W(TW), .OUT_W(4)) uut (.*);

  initial clk = 1'b0;
  always #5 clk = ~clk;

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic idle_inputs();
    s_awvalid = 0; s_wvalid = 0; s_bready = 0; s_arvalid = 0; s_rready = 0;
    s_awaddr = '0; s_araddr = '0; s_wdata = '0; s_wstrb = '1;
    m_awready = 0; m_wready = 0; m_bvalid = 0; m_bresp = 0;
    m_arready = 0; m_rvalid = 0; m_rdata = '0; m_rresp = 0;
  endtask

  task automatic do_reset(input int lim);
    @(negedge clk);
    idle_inputs();
    stall_limit = {5{TW'(lim)}};
    rst_n = 0;
    repeat (2) @(negedge clk);
    rst_n = 1;
    repeat (3) @(negedge clk);
  endtask

  // counts edges until tripped; also checks the one-cycle interrupt (R8)
  task automatic measure(input string tag, input int exp_n, input logic [6:0] exp_stat);
    int n = 0;
    while (!tripped && n < 40) begin
      @(negedge clk);
      n++;
    end
    check({tag, " trip cycle"}, n, exp_n);
    check({tag, " R7 cause"}, trip_status, exp_stat);
    check({tag, " R8 irq high"}, trip_irq, 1);
    @(negedge clk);
    check({tag, " R8 irq low"}, trip_irq, 0);
  endtask

  task automatic hs_write();
    s_awvalid = 1; s_wvalid = 1; m_awready = 1; m_wready = 1;
    @(negedge clk);
    s_awvalid = 0; s_wvalid = 0; m_awready = 0; m_wready = 0;
  endtask

  task automatic hs_read();
    s_arvalid = 1; m_arready = 1;
    @(negedge clk);
    s_arvalid = 0; m_arready = 0;
  endtask

  initial begin
    #1ms;
    n_fail++;
    $display("FAIL watchdog expired");
    $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end

  initial begin
    rst_n = 0;
    idle_inputs();
    stall_limit = '0;
    do_reset(8);
    // R1 reset state
    check("R1 tripped", tripped, 0);
    check("R1 irq", trip_irq, 0);
    check("R1 status", trip_status, 0);

    // R2 pass-through sweep
    for (int i = 0; i < 4; i++) begin
      logic [31:0] d;
      d = 32'h1000_0000 + i * 32'h0111_0101;
      @(negedge clk);
      s_awaddr = AW'(16 + 4 * i); s_wdata = d; s_wstrb = 4'(i + 1);
      s_awvalid = 1; s_wvalid = 1; m_awready = 1; m_wready = 1;
      #1;
      check("R2 awvalid", m_awvalid, 1);
      check("R2 awaddr", m_awaddr, 16 + 4 * i);
      check("R2 wdata", m_wdata, d);
      check("R2 wstrb", m_wstrb, i + 1);
      check("R2 awready", s_awready, 1);
      @(negedge clk);
      s_awvalid = 0; s_wvalid = 0; m_awready = 0; m_wready = 0;
      m_bvalid = 1; m_bresp = 2'(i); s_bready = 1;
      #1;
      check("R2 bvalid", s_bvalid, 1);
      check("R2 bresp", s_bresp, i);
      check("R2 bready", m_bready, 1);
      @(negedge clk);
      m_bvalid = 0; s_bready = 0;
      s_araddr = AW'(64 + i); s_arvalid = 1; m_arready = 1;
      #1;
      check("R2 araddr", m_araddr, 64 + i);
      @(negedge clk);
      s_arvalid = 0; m_arready = 0;
      m_rvalid = 1; m_rdata = ~d; m_rresp = 2'(3 - i); s_rready = 1;
      #1;
      check("R2 rdata", s_rdata, ~d);
      check("R2 rresp", s_rresp, 3 - i);
      @(negedge clk);
      m_rvalid = 0; s_rready = 0;
      check("R2 no trip", tripped, 0);
    end

    // R3 / R4 stall sweep: every channel, limits 1..4
    for (int ch = 0; ch < 5; ch++) begin
      for (int lim = 1; lim <= 4; lim++) begin
        do_reset(lim);
        case (ch)
          0: s_awvalid = 1;
          1: s_wvalid = 1;
          3: s_arvalid = 1;
          2: hs_write();
          default: hs_read();
        endcase
        measure((ch == 2 || ch == 4) ? "R4 stall" : "R3 stall", lim + 1,
                7'h20 | 7'(1 << ch));
        if (ch == 2) begin
          check("R10 owed B valid", s_bvalid, 1);
          check("R10 owed B resp", s_bresp, 2);
        end
        if (ch == 4) begin
          check("R10 owed R valid", s_rvalid, 1);
          check("R10 owed R data", s_rdata, 0);
        end
      end
    end

    // R5 unexpected write response
    do_reset(10);
    m_bvalid = 1;
    measure("R5 stray B", 1, 7'h44);
    m_bvalid = 0;

    // R9 / R10 after trip: new write and read answered locally
    s_awvalid = 1; s_wvalid = 1; m_awready = 1; m_wready = 1; s_bready = 0;
    #1;
    check("R9 awvalid blocked", m_awvalid, 0);
    check("R9 wvalid blocked", m_wvalid, 0);
    check("R10 aw accepted", s_awready, 1);
    check("R10 w accepted", s_wready, 1);
    @(negedge clk);
    s_awvalid = 0; s_wvalid = 0; m_bvalid = 1; m_bresp = 0;
    #1;
    check("R10 B valid", s_bvalid, 1);
    check("R10 B resp", s_bresp, 2);
    check("R9 bready blocked", m_bready, 0);
    s_bready = 1;
    @(negedge clk);
    s_bready = 0; m_bvalid = 0;
    check("R10 B done", s_bvalid, 0);
    s_arvalid = 1; m_arready = 1; m_rvalid = 1; m_rdata = 32'hDEAD_BEEF;
    #1;
    check("R9 arvalid blocked", m_arvalid, 0);
    check("R10 ar accepted", s_arready, 1);
    @(negedge clk);
    s_arvalid = 0; s_rready = 1;
    #1;
    check("R10 R valid", s_rvalid, 1);
    check("R10 R data zero", s_rdata, 0);
    check("R10 R resp", s_rresp, 2);
    check("R9 rready blocked", m_rready, 0);
    @(negedge clk);
    s_rready = 0; m_rvalid = 0; m_arready = 0;
    check("R10 R done", s_rvalid, 0);

    // R11 sticky through idle time, cleared by reset
    repeat (50) @(negedge clk);
    check("R11 still tripped", tripped, 1);
    check("R11 status frozen", trip_status, 7'h44);
    do_reset(10);
    check("R11 reset clears", tripped, 0);
    check("R1 status cleared", trip_status, 0);

    // R5 unexpected read response
    do_reset(10);
    m_rvalid = 1;
    measure("R5 stray R", 1, 7'h50);
    m_rvalid = 0;

    // R6 slave withdraws RVALID before RREADY
    do_reset(10);
    hs_read();
    m_rvalid = 1; s_rready = 0;
    @(negedge clk);
    check("R6 not yet", tripped, 0);
    m_rvalid = 0;
    measure("R6 R drop", 1, 7'h50);

    // R6 master withdraws AWVALID before AWREADY
    do_reset(10);
    s_awvalid = 1;
    @(negedge clk);
    s_awvalid = 0;
    measure("R6 AW drop", 1, 7'h41);

    // R12 two channels expire on the same edge
    do_reset(3);
    s_awvalid = 1; s_arvalid = 1;
    measure("R12 AW+AR", 4, 7'h29);

    // R12 stall and violation in the same cycle
    do_reset(2);
    s_wvalid = 1;
    repeat (2) @(negedge clk);
    m_bvalid = 1;
    measure("R12 W stall + stray B", 1, 7'h66);

    idle_inputs();
    $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end
endmodule